// File: doc/BRIEF.md
# ATM Transmit Channel Sequencer

This block holds the transmit control of one ATM virtual channel. An external cell scheduler pulses `grant` each time the channel owns a cell slot. On every grant that the block accepts, it does one of three things. It emits one cell, which is the channel's stored 4-byte header followed by a 48-byte payload. It reports that the next transmit buffer is not ready. Or it acts on a stop request from the host. Payload bytes are fetched from a byte-addressed buffer memory through a combinational read port. The buffer in use is taken from a table of buffer descriptors, which is read through a second combinational port.

The channel keeps the pointer into its open buffer and a count of the bytes still to be sent. It also keeps its position in the descriptor table and a flag that marks a frame in progress. Three adaptation modes are supported. In raw segmentation, 48 buffer bytes go into each cell. In AAL1, the first payload byte is a reserved placeholder and 47 buffer bytes follow it. In AAL5, 48 bytes go into each cell and a frame in progress is tracked. A host stop is held until the channel's next grant. If it arrives in the middle of an AAL5 frame, it produces a final cell whose payload is all zero, so the frame's length field reads zero.

Top module: `atm_tx_chan_seq`

## Requirements
- R1: After synchronous reset, `chan_active`, `in_frame`, `tx_valid` and `bnr_event` are 0, and the descriptor offset is 0, so the first descriptor read uses table slot `cfg_tbl_base`.
- R2: An accepted grant emits exactly one cell of 52 bytes: the header bytes `cfg_hdr[31:24]`, `[23:16]`, `[15:8]`, `[7:0]`, then 48 payload bytes, with `tx_last` high on the 52nd byte only. A grant is ignored while `chan_active` is 0 or while a cell is still being output.
- R3: A byte is transferred when `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R4: When `cfg_mode` is 000 (raw) or 010 (AAL5), payload byte k is the buffer byte at pointer+k. Payload bytes at or beyond the remaining count are 0x00. The remaining count is reduced by 48, and stops at zero. Reserved mode codes behave as raw.
- R5: When `cfg_mode` is 001 (AAL1), the first payload byte is 0x00, and payload byte k≥1 is the buffer byte at pointer+k-1. Bytes at or beyond the remaining count are 0x00. The count and the pointer advance by 47.
- R6: A descriptor is read (`desc_rd` high, in the grant cycle) only when no buffer is open. `desc_addr` = {`cfg_addr_ext`, (`cfg_tbl_base` + offset) mod 256, 4'b0000}. A ready descriptor loads the pointer from `desc_ptr` and the remaining count from `desc_len`.
- R7: When a cell brings the remaining count to zero, the buffer closes and the offset advances by one slot. The offset wraps to 0 instead if the buffer's descriptor had `desc_last` set.
- R8: If the descriptor read on a grant has `desc_rdy` = 0, no cell is sent and the offset is kept, so the same slot is read on the next grant. `bnr_event` pulses one cycle after the grant when `bnr_mask` is 1, and stays 0 when it is 0.
- R9: A `chan_stop` pulse changes nothing until the next accepted grant. At that grant `chan_active` clears. No cell is sent unless R11 applies.
- R10: After a data cell in AAL5 mode, `in_frame` is 1 exactly when the buffer is still open. In other modes, `in_frame` clears when a buffer closes and is otherwise unchanged.
- R11: A stop acted on in AAL5 mode while `in_frame` is 1 emits one cell made of the header and 48 zero payload bytes. That grant also clears `in_frame` and `chan_active`, drops the rest of the buffer, and advances the offset as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 3 | Adaptation mode code |
| cfg_hdr | input | 32 | Cell header attached ahead of each payload |
| cfg_tbl_base | input | 8 | Descriptor table base slot |
| cfg_addr_ext | input | 8 | Upper descriptor address bits |
| bnr_mask | input | 1 | 1 lets the buffer-not-ready event through |
| chan_start | input | 1 | Pulse: activate the channel |
| chan_stop | input | 1 | Pulse: request a stop at the next grant |
| grant | input | 1 | Scheduler slot grant pulse |
| desc_rd | output | 1 | Descriptor read strobe |
| desc_addr | output | 20 | Descriptor address |
| desc_rdy | input | 1 | Descriptor ready flag |
| desc_last | input | 1 | Descriptor is last in the table |
| desc_len | input | 16 | Descriptor byte length |
| desc_ptr | input | 32 | Descriptor buffer pointer |
| buf_addr | output | 32 | Payload byte read address |
| buf_byte | input | 8 | Payload byte read data |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Output byte accepted |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of a cell |
| bnr_event | output | 1 | Buffer-not-ready event pulse |
| chan_active | output | 1 | Channel active flag |
| in_frame | output | 1 | AAL5 frame in progress |

## Verification
A directed table of three descriptors is placed so that it crosses slot 255. This checks the wrap of the base-plus-offset sum and the wrap on the last-descriptor flag. The buffer lengths in that table are a multiple of 48, one cell long, and shorter than a cell, so the padding case is kept apart from an exact fill. Random buffer lengths, readiness and mask values are then run in raw, AAL1 and AAL5 modes, with output back-pressure. This separates the 47-byte and 48-byte consumption, shows that masked and unmasked not-ready events differ, and shows that a not-ready read is retried at the same slot. Stop requests are tried both outside a frame and in the middle of an AAL5 frame. This tells the plain deactivation apart from the zero-length abort cell, and confirms that nothing happens before the grant.

// File: rtl/atm_txq_pkg.sv
package atm_txq_pkg;

    localparam int BUF_PTR_W = 32;
    localparam int BUF_LEN_W = 16;
    localparam int HDR_BYTES = 4;
    localparam int PAY_BYTES = 48;
    localparam int CELL_BYTES = HDR_BYTES + PAY_BYTES;
    localparam int IDX_W = $clog2(CELL_BYTES);
    localparam int TAKE_W = $clog2(PAY_BYTES + 1);

    localparam logic [2:0] MODE_AAL1 = 3'b001;
    localparam logic [2:0] MODE_AAL5 = 3'b010;

    typedef enum logic [1:0] {
        CELL_DATA  = 2'd0,
        CELL_AAL1  = 2'd1,
        CELL_ABORT = 2'd2
    } cell_kind_e;

    typedef struct packed {
        logic [BUF_PTR_W-1:0] ptr;
        logic [BUF_LEN_W-1:0] rem;
        logic                 last;
    } buf_ctx_t;

    function automatic logic [TAKE_W-1:0] cell_take(cell_kind_e k);
        return (k == CELL_AAL1) ? TAKE_W'(PAY_BYTES - 1) : TAKE_W'(PAY_BYTES);
    endfunction

    function automatic logic [7:0] hdr_byte(logic [31:0] h, logic [1:0] i);
        logic [7:0] b;
        case (i)
            2'd0:    b = h[31:24];
            2'd1:    b = h[23:16];
            2'd2:    b = h[15:8];
            default: b = h[7:0];
        endcase
        return b;
    endfunction

endpackage

// File: rtl/txq_bd_walker.sv
module txq_bd_walker #(
    parameter int EXT_W    = 8,
    parameter int TBL_W    = 8,
    parameter int SLOT_LSB = 4,
    localparam int DA_W    = EXT_W + TBL_W + SLOT_LSB
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [EXT_W-1:0] ext,
    input  logic [TBL_W-1:0] base,
    input  logic             advance,
    input  logic             wrap,
    output logic [DA_W-1:0]  desc_addr
);

    logic [TBL_W-1:0] offset_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            offset_q <= '0;
        end else if (advance) begin
            offset_q <= wrap ? '0 : offset_q + 1'b1;
        end
    end

    always_comb begin
        desc_addr = {ext, base + offset_q, {SLOT_LSB{1'b0}}};
    end

endmodule

// File: rtl/txq_cell_emitter.sv
module txq_cell_emitter
    import atm_txq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  cell_kind_e           kind,
    input  logic [31:0]          hdr,
    input  logic [BUF_PTR_W-1:0] ptr,
    input  logic [BUF_LEN_W-1:0] rem,
    input  logic                 tx_ready,
    input  logic [7:0]           buf_byte,
    output logic                 busy,
    output logic [7:0]           tx_data,
    output logic                 tx_last,
    output logic [BUF_PTR_W-1:0] buf_addr
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);

    logic                 busy_q;
    logic [IDX_W-1:0]     idx_q;
    cell_kind_e           kind_q;
    logic [31:0]          hdr_q;
    logic [BUF_PTR_W-1:0] ptr_q;
    logic [BUF_LEN_W-1:0] rem_q;

    logic [IDX_W-1:0] pay_i;
    logic [IDX_W-1:0] data_i;
    logic             in_buf;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            kind_q <= CELL_DATA;
            hdr_q  <= '0;
            ptr_q  <= '0;
            rem_q  <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            kind_q <= kind;
            hdr_q  <= hdr;
            ptr_q  <= ptr;
            rem_q  <= rem;
        end else if (busy_q && tx_ready) begin
            if (idx_q == LAST_IDX) begin
                busy_q <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    always_comb begin
        pay_i    = idx_q - IDX_W'(HDR_BYTES);
        data_i   = (kind_q == CELL_AAL1) ? pay_i - 1'b1 : pay_i;
        buf_addr = ptr_q + BUF_PTR_W'(data_i);
        in_buf   = BUF_LEN_W'(data_i) < rem_q;
        if (idx_q < IDX_W'(HDR_BYTES)) begin
            tx_data = hdr_byte(hdr_q, idx_q[1:0]);
        end else if (kind_q == CELL_ABORT) begin
            tx_data = 8'h00;
        end else if (kind_q == CELL_AAL1 && pay_i == '0) begin
            tx_data = 8'h00;
        end else begin
            tx_data = in_buf ? buf_byte : 8'h00;
        end
        busy    = busy_q;
        tx_last = busy_q && (idx_q == LAST_IDX);
    end

endmodule

// File: rtl/atm_tx_chan_seq.sv
module atm_tx_chan_seq
    import atm_txq_pkg::*;
#(
    parameter int EXT_W    = 8,
    parameter int TBL_W    = 8,
    parameter int SLOT_LSB = 4,
    localparam int DA_W    = EXT_W + TBL_W + SLOT_LSB
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2:0]           cfg_mode,
    input  logic [31:0]          cfg_hdr,
    input  logic [TBL_W-1:0]     cfg_tbl_base,
    input  logic [EXT_W-1:0]     cfg_addr_ext,
    input  logic                 bnr_mask,
    input  logic                 chan_start,
    input  logic                 chan_stop,
    input  logic                 grant,
    output logic                 desc_rd,
    output logic [DA_W-1:0]      desc_addr,
    input  logic                 desc_rdy,
    input  logic                 desc_last,
    input  logic [BUF_LEN_W-1:0] desc_len,
    input  logic [BUF_PTR_W-1:0] desc_ptr,
    output logic [BUF_PTR_W-1:0] buf_addr,
    input  logic [7:0]           buf_byte,
    output logic                 tx_valid,
    input  logic                 tx_ready,
    output logic [7:0]           tx_data,
    output logic                 tx_last,
    output logic                 bnr_event,
    output logic                 chan_active,
    output logic                 in_frame
);

    // channel state
    logic     active_q;
    logic     stop_q;
    logic     open_q;
    logic     inframe_q;
    logic     bnr_q;
    buf_ctx_t ctx_q;

    // grant decisions
    logic        em_busy;
    logic        accept;
    logic        do_stop;
    logic        do_abort;
    logic        need_bd;
    logic        do_data;
    logic        close_buf;
    logic        wrap_sel;
    logic        is_aal5;
    cell_kind_e  kind;
    buf_ctx_t    cur;
    logic [TAKE_W-1:0]    take;
    logic [BUF_LEN_W-1:0] left;

    always_comb begin
        is_aal5  = (cfg_mode == MODE_AAL5);
        accept   = grant && active_q && !em_busy;
        do_stop  = accept && stop_q;
        do_abort = do_stop && is_aal5 && inframe_q;
        need_bd  = accept && !stop_q && !open_q;
        do_data  = accept && !stop_q && (open_q || desc_rdy);

        if (open_q) begin
            cur = ctx_q;
        end else begin
            cur.ptr  = desc_ptr;
            cur.rem  = desc_len;
            cur.last = desc_last;
        end

        if (do_abort) begin
            kind = CELL_ABORT;
        end else if (cfg_mode == MODE_AAL1) begin
            kind = CELL_AAL1;
        end else begin
            kind = CELL_DATA;
        end

        take      = cell_take(kind);
        left      = (cur.rem > BUF_LEN_W'(take)) ? cur.rem - BUF_LEN_W'(take) : '0;
        close_buf = (do_data && left == '0) || do_abort;
        wrap_sel  = do_abort ? ctx_q.last : cur.last;
        desc_rd   = need_bd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q  <= 1'b0;
            stop_q    <= 1'b0;
            open_q    <= 1'b0;
            inframe_q <= 1'b0;
            bnr_q     <= 1'b0;
            ctx_q     <= '0;
        end else begin
            bnr_q <= need_bd && !desc_rdy && bnr_mask;

            if (chan_start) begin
                active_q <= 1'b1;
            end else if (do_stop) begin
                active_q <= 1'b0;
            end

            if (do_stop) begin
                stop_q <= 1'b0;
            end else if (chan_stop) begin
                stop_q <= 1'b1;
            end

            if (do_abort) begin
                open_q    <= 1'b0;
                inframe_q <= 1'b0;
                ctx_q.rem <= '0;
            end else if (do_data) begin
                open_q     <= (left != '0);
                ctx_q.ptr  <= cur.ptr + BUF_PTR_W'(take);
                ctx_q.rem  <= left;
                ctx_q.last <= cur.last;
                if (is_aal5) begin
                    inframe_q <= (left != '0);
                end else if (left == '0) begin
                    inframe_q <= 1'b0;
                end
            end
        end
    end

    txq_bd_walker #(
        .EXT_W    (EXT_W),
        .TBL_W    (TBL_W),
        .SLOT_LSB (SLOT_LSB)
    ) u_walker (
        .clk       (clk),
        .rst       (rst),
        .ext       (cfg_addr_ext),
        .base      (cfg_tbl_base),
        .advance   (close_buf),
        .wrap      (wrap_sel),
        .desc_addr (desc_addr)
    );

    txq_cell_emitter u_emit (
        .clk      (clk),
        .rst      (rst),
        .start    (do_data || do_abort),
        .kind     (kind),
        .hdr      (cfg_hdr),
        .ptr      (cur.ptr),
        .rem      (do_abort ? '0 : cur.rem),
        .tx_ready (tx_ready),
        .buf_byte (buf_byte),
        .busy     (em_busy),
        .tx_data  (tx_data),
        .tx_last  (tx_last),
        .buf_addr (buf_addr)
    );

    always_comb begin
        tx_valid    = em_busy;
        bnr_event   = bnr_q;
        chan_active = active_q;
        in_frame    = inframe_q;
    end

endmodule

// File: rtl/atm_tx_chan_seq_chk.sv
module atm_tx_chan_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] cfg_mode,
    input logic       bnr_mask,
    input logic       grant,
    input logic       desc_rd,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic       tx_last,
    input logic       bnr_event,
    input logic       chan_active,
    input logic       in_frame
);

    a_r3_hold_under_backpressure: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    a_r2_one_cell_per_grant: assert property (@(posedge clk) disable iff (rst)
        tx_valid && tx_ready && tx_last |=> !tx_valid);

    a_r2_cell_needs_grant: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> $past(grant) && $past(chan_active));

    a_r8_event_respects_mask: assert property (@(posedge clk) disable iff (rst)
        bnr_event |-> $past(bnr_mask) && !tx_valid);

    a_r6_read_only_between_cells: assert property (@(posedge clk) disable iff (rst)
        desc_rd |-> grant && !tx_valid && chan_active);

    a_r9_stop_only_at_grant: assert property (@(posedge clk) disable iff (rst)
        $fell(chan_active) |-> $past(grant));

    a_r10_frame_starts_in_aal5: assert property (@(posedge clk) disable iff (rst)
        $rose(in_frame) |-> $past(cfg_mode) == 3'b010 && tx_valid);

endmodule

bind atm_tx_chan_seq atm_tx_chan_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_mode    (cfg_mode),
    .bnr_mask    (bnr_mask),
    .grant       (grant),
    .desc_rd     (desc_rd),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_data     (tx_data),
    .tx_last     (tx_last),
    .bnr_event   (bnr_event),
    .chan_active (chan_active),
    .in_frame    (in_frame)
);

// File: tb/atm_tx_chan_seq_test.sv
`timescale 1ns/1ps
module atm_tx_chan_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cfg_mode = 3'd0;
    logic [31:0] cfg_hdr = 32'h1234_5678;
    logic [7:0]  cfg_tbl_base = 8'hFE;
    logic [7:0]  cfg_addr_ext = 8'hA5;
    logic        bnr_mask = 1'b1;
    logic        chan_start = 1'b0;
    logic        chan_stop = 1'b0;
    logic        grant = 1'b0;
    logic        desc_rd;
    logic [19:0] desc_addr;
    logic        desc_rdy;
    logic        desc_last;
    logic [15:0] desc_len;
    logic [31:0] desc_ptr;
    logic [31:0] buf_addr;
    logic [7:0]  buf_byte;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic        tx_last;
    logic        bnr_event;
    logic        chan_active;
    logic        in_frame;

    always #2.5 clk = ~clk;

    atm_tx_chan_seq uut (.*);

    // descriptor table and buffer memory models
    bit          t_rdy  [256];
    bit          t_last [256];
    logic [15:0] t_len  [256];
    logic [31:0] t_ptr  [256];

    function automatic logic [7:0] mem_of(logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    always_comb begin
        desc_rdy  = t_rdy[desc_addr[11:4]];
        desc_last = t_last[desc_addr[11:4]];
        desc_len  = t_len[desc_addr[11:4]];
        desc_ptr  = t_ptr[desc_addr[11:4]];
        buf_byte  = mem_of(buf_addr);
    end

    int total = 0;
    int bad = 0;
    bit done_flag = 0;

    // reference state
    bit          m_active, m_stop, m_open, m_last, m_inf;
    logic [31:0] m_ptr;
    int          m_rem;
    logic [7:0]  m_off;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(int kind, logic [31:0] hdr, logic [31:0] p,
                                            int rem, int i);
        int pi, d;
        if (i < 4) return hdr[31-8*i -: 8];
        pi = i - 4;
        if (kind == 2) return 8'h00;
        if (kind == 1) begin
            if (pi == 0) return 8'h00;
            d = pi - 1;
        end else begin
            d = pi;
        end
        return (d < rem) ? mem_of(p + d) : 8'h00;
    endfunction

    function automatic void advance_off();
        m_off = m_last ? 8'h00 : m_off + 8'h01;
    endfunction

    task automatic do_grant(string req, bit busy_grant);
        bit exp_rd = 0, exp_cell = 0, exp_bnr = 0, miss = 0;
        int kind = 0, take, c_rem = 0;
        logic [31:0] c_ptr = 0;
        logic [7:0]  slot;
        logic [19:0] exp_addr;
        slot = cfg_tbl_base + m_off;
        exp_addr = {cfg_addr_ext, slot, 4'h0};
        if (m_active) begin
            if (m_stop) begin
                m_stop = 0;
                m_active = 0;
                if (cfg_mode == 3'd2 && m_inf) begin
                    exp_cell = 1; kind = 2; m_inf = 0; m_open = 0;
                    advance_off();
                end
            end else begin
                if (!m_open) begin
                    exp_rd = 1;
                    if (t_rdy[slot]) begin
                        m_open = 1; m_ptr = t_ptr[slot]; m_rem = int'(t_len[slot]);
                        m_last = t_last[slot];
                    end else begin
                        miss = 1; exp_bnr = bnr_mask;
                    end
                end
                if (m_open) begin
                    exp_cell = 1;
                    kind = (cfg_mode == 3'd1) ? 1 : 0;
                    take = (kind == 1) ? 47 : 48;
                    c_ptr = m_ptr; c_rem = m_rem;
                    m_ptr = m_ptr + take;
                    m_rem = (m_rem > take) ? m_rem - take : 0;
                    if (m_rem == 0) begin
                        m_open = 0;
                        advance_off();
                    end
                    if (cfg_mode == 3'd2) m_inf = m_open;
                    else if (!m_open) m_inf = 0;
                end
            end
        end
        @(negedge clk);
        grant = 1;
        #1;
        chk(desc_rd == exp_rd, exp_rd ? "R6" : "R2", "desc_rd", desc_rd, exp_rd);
        if (exp_rd)
            chk(desc_addr == exp_addr, "R6", "desc_addr", desc_addr, exp_addr);
        @(negedge clk);
        grant = 0;
        chk(bnr_event == exp_bnr, "R8", "bnr_event", bnr_event, exp_bnr);
        chk(tx_valid == exp_cell, req, "cell started", tx_valid, exp_cell);
        if (exp_cell && tx_valid) begin
            int n = 0, it = 0, errs = 0;
            logic [7:0] fa = 0, fe = 0;
            while (n < 52 && it < 4000) begin
                grant = busy_grant && (it == 5);
                tx_ready = ($urandom % 4) != 0;
                #0.5;
                if (tx_valid && tx_ready) begin
                    logic [7:0] e;
                    e = exp_byte(kind, cfg_hdr, c_ptr, c_rem, n);
                    if (tx_data !== e || tx_last !== (n == 51)) begin
                        if (errs == 0) begin fa = tx_data; fe = e; end
                        errs++;
                    end
                    n++;
                end
                it++;
                @(negedge clk);
            end
            grant = 0;
            tx_ready = 0;
            chk(errs == 0 && n == 52, kind == 2 ? "R11" : (kind == 1 ? "R5" : "R4"),
                "cell bytes", fa, fe);
            chk(tx_valid == 0, "R2", "idle after cell", tx_valid, 0);
        end
        if (miss) t_rdy[slot] = 1;
        chk(chan_active == m_active, "R9", "chan_active", chan_active, m_active);
        chk(in_frame == m_inf, "R10", "in_frame", in_frame, m_inf);
    endtask

    task automatic fill_table(logic [7:0] base, int n, int maxlen);
        for (int i = 0; i < n; i++) begin
            logic [7:0] s;
            s = base + i[7:0];
            t_rdy[s]  = ($urandom % 7) != 0;
            t_last[s] = (i == n - 1);
            t_len[s]  = 16'(1 + $urandom % maxlen);
            t_ptr[s]  = $urandom;
        end
    endtask

    task automatic start_chan();
        @(negedge clk); chan_start = 1;
        @(negedge clk); chan_start = 0;
        m_active = 1;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done_flag) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_active = 0; m_stop = 0; m_open = 0; m_last = 0; m_inf = 0;
        m_ptr = 0; m_rem = 0; m_off = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(chan_active == 0, "R1", "chan_active", chan_active, 0);
        chk(in_frame == 0, "R1", "in_frame", in_frame, 0);
        chk(tx_valid == 0, "R1", "tx_valid", tx_valid, 0);
        chk(bnr_event == 0, "R1", "bnr_event", bnr_event, 0);
        // R2 inactive grant ignored
        do_grant("R2", 0);

        // directed raw table crossing slot 255: lengths 96, 48, 20
        t_rdy[8'hFE] = 1; t_last[8'hFE] = 0; t_len[8'hFE] = 16'd96; t_ptr[8'hFE] = 32'h0000_1000;
        t_rdy[8'hFF] = 1; t_last[8'hFF] = 0; t_len[8'hFF] = 16'd48; t_ptr[8'hFF] = 32'h0000_2233;
        t_rdy[8'h00] = 1; t_last[8'h00] = 1; t_len[8'h00] = 16'd20; t_ptr[8'h00] = 32'h0000_3FF0;
        start_chan();
        for (int i = 0; i < 6; i++) do_grant("R7", i == 1);

        // R8 not-ready, masked and unmasked
        t_rdy[8'hFE] = 0; t_len[8'hFE] = 16'd50;
        bnr_mask = 0; do_grant("R8", 0);
        t_rdy[8'hFE] = 0;
        do_grant("R8", 0);
        bnr_mask = 1; t_rdy[8'hFF] = 0;
        do_grant("R8", 0);
        do_grant("R8", 0);

        // random raw
        cfg_tbl_base = 8'h40;
        fill_table(8'h40, 5, 160);
        for (int i = 0; i < 25; i++) begin
            bnr_mask = $urandom % 2;
            cfg_hdr = $urandom;
            do_grant("R4", 0);
        end

        // R9 stop outside a frame
        @(negedge clk); chan_stop = 1;
        @(negedge clk); chan_stop = 0;
        m_stop = 1;
        repeat (3) @(negedge clk);
        chk(chan_active == 1, "R9", "active before grant", chan_active, 1);
        do_grant("R9", 0);
        do_grant("R9", 0);

        // AAL1
        cfg_mode = 3'd1;
        start_chan();
        fill_table(8'h40, 5, 160);
        for (int i = 0; i < 20; i++) begin
            bnr_mask = $urandom % 2;
            do_grant("R5", 0);
        end

        // AAL5
        cfg_mode = 3'd2;
        cfg_tbl_base = 8'h80;
        fill_table(8'h80, 6, 200);
        for (int i = 0; i < 25; i++) do_grant("R10", 0);
        // reach the middle of a frame, then stop: abort cell
        t_rdy[cfg_tbl_base + m_off] = 1;
        t_len[cfg_tbl_base + m_off] = 16'd190;
        for (int i = 0; i < 12 && !m_inf; i++) do_grant("R10", 0);
        chk(in_frame == 1, "R11", "in frame before stop", in_frame, 1);
        @(negedge clk); chan_stop = 1;
        @(negedge clk); chan_stop = 0;
        m_stop = 1;
        do_grant("R11", 0);
        start_chan();
        t_rdy[cfg_tbl_base + m_off] = 1;
        do_grant("R11", 0);
        for (int i = 0; i < 6; i++) do_grant("R10", 0);

        done_flag = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule